// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Controller

This block lets a radio receiver poll the air at low average power. Once duty cycling is enabled it alternates between a sleep period, with the receiver disabled, and a listen window, with the receiver enabled. The length of each period is a 16-bit count multiplied by one of four time bases. A host CPU reaches the block through a byte-wide write port. It is woken through a shared, pulled-up handshake line.

The host keeps the receiver awake by pulling the handshake line low at some point during a listen window. If the line is still low when the window runs out, the receiver stays enabled until the host lets go. If the line is high at that moment, the receiver shuts down and the sleep period starts again. A programmed listen count of zero means no listen window. The block then goes from one sleep period straight into the next.

The line is resolved with a weak-high default and passes through a two-flop synchroniser before the controller uses it. All durations come from one prescaler. That prescaler is restarted at the beginning of every period, so each period lasts an exact number of clock cycles.

Top module: `rxw_ctrl`

## Requirements
- R1: After reset, rx_en is 0 and all registers hold zero: both counts are 0, duty cycling is disabled, and both base selects are 00.
- R2: A write sets a register when wr_en is 1. The register map is as follows. Address 0x0A is control: bit 0 enables duty cycling, bits 2:1 select the listen time base, and bits 4:3 select the sleep time base. Address 0x0B holds the listen count upper byte and 0x0C its lower byte. Address 0x0D holds the sleep count upper byte and 0x0E its lower byte. A write to any other address changes nothing.
- R3: A time base of BASE_CYCLES × 4^sel clock cycles is selected by each 2-bit select. With sel = 00, 01, 10 and 11 this gives 1, 4, 16 and 64 × BASE_CYCLES.
- R4: A listen window with count N ≥ 1 keeps rx_en high for exactly N × (listen time base) cycles when the line is high at its end.
- R5: A sleep period with count M ≥ 1 keeps rx_en low for exactly M × (sleep time base) cycles between two listen windows.
- R6: While idle and enabled, the sequence starts once the synchronised line is high. It starts with a sleep period. If the host releases the line at a falling clock edge, rx_en rises at the (3 + M × sleep base)-th falling edge after that release.
- R7: A listen count of zero produces no listen window. rx_en stays 0 and sleep periods follow one another.
- R8: If the synchronised line is low in the cycle in which a listen window ends, rx_en stays high. It stays high until the line is seen high again. rx_en then falls at the third falling edge after the host releases the line.
- R9: If the synchronised line is high in the cycle in which a listen window ends, rx_en falls at once and a full sleep period follows.
- R10: Writing 0 to the enable bit returns the block to idle. rx_en falls at the second falling clock edge after the write's falling edge and stays low.
- R11: line_level equals host_level while host_oe is 1, and is 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| host_oe | input | 1 | Host actively drives the handshake line |
| host_level | input | 1 | Level the host drives when host_oe is 1 |
| line_level | output | 1 | Resolved handshake line level (weak high when undriven) |
| rx_en | output | 1 | Receiver enable |

## Verification
Two events can fall in the same cycle: the end of a listen window, and a change of the synchronised handshake line as the host releases it. The bench holds the line low from the start of a window. It then releases it at falling edges chosen so that the synchronised level turns high either exactly in the expiry cycle or one cycle later. The first case must give a window of exactly N × base cycles followed by a full sleep period. The second must give one extra cycle of rx_en through the hold state.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_OFF  = 2'd1,
    ST_ON   = 2'd2,
    ST_HOLD = 2'd3
  } rxw_state_e;

  localparam logic [7:0] ADDR_CTRL   = 8'h0A;
  localparam logic [7:0] ADDR_ON_HI  = 8'h0B;
  localparam logic [7:0] ADDR_ON_LO  = 8'h0C;
  localparam logic [7:0] ADDR_OFF_HI = 8'h0D;
  localparam logic [7:0] ADDR_OFF_LO = 8'h0E;

  // Cycles per time-base tick: each select step is four times the last.
  function automatic int unsigned tick_cycles(input int unsigned base,
                                              input logic [1:0] sel);
    return base << (2 * int'(sel));
  endfunction

  function automatic logic addr_mapped(input logic [7:0] a);
    return (a == ADDR_CTRL) || (a == ADDR_ON_HI) || (a == ADDR_ON_LO) ||
           (a == ADDR_OFF_HI) || (a == ADDR_OFF_LO);
  endfunction

endpackage

// File: rtl/rxw_regfile.sv
module rxw_regfile
  import rxw_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  output logic             cyc_en,
  output logic [1:0]       on_sel,
  output logic [1:0]       off_sel,
  output logic [CNT_W-1:0] on_cnt,
  output logic [CNT_W-1:0] off_cnt
);

  localparam int HI_W = CNT_W - 8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_en  <= 1'b0;
      on_sel  <= 2'b00;
      off_sel <= 2'b00;
    end else if (wr_en && wr_addr == ADDR_CTRL) begin
      cyc_en  <= wr_data[0];
      on_sel  <= wr_data[2:1];
      off_sel <= wr_data[4:3];
    end
  end

  // One split-byte count register per timer; index 0 listen, 1 sleep.
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    localparam logic [7:0] A_HI = (g == 0) ? ADDR_ON_HI : ADDR_OFF_HI;
    localparam logic [7:0] A_LO = (g == 0) ? ADDR_ON_LO : ADDR_OFF_LO;
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (wr_en && wr_addr == A_HI) begin
        q[CNT_W-1:8] <= wr_data[HI_W-1:0];
      end else if (wr_en && wr_addr == A_LO) begin
        q[7:0] <= wr_data;
      end
    end
  end

  assign on_cnt  = g_cnt[0].q;
  assign off_cnt = g_cnt[1].q;

  AST_UNMAPPED_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_mapped(wr_addr)) |=> ($stable(on_cnt) && $stable(off_cnt) && $stable(cyc_en) && $stable(on_sel) && $stable(off_sel))); // R2

endmodule

// File: rtl/rxw_prescaler.sv
module rxw_prescaler
  import rxw_pkg::*;
#(
  parameter int BASE_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic [1:0] sel,
  output logic       tick
);

  localparam int PW = $clog2(BASE_CYCLES * 64 + 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] period;

  assign period = PW'(tick_cycles(BASE_CYCLES, sel));
  // Greater-or-equal guards against a select that shrinks mid-period.
  assign tick = (cnt >= period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  initial begin
    assert (BASE_CYCLES >= 2) else $error("BASE_CYCLES below 2");
  end

  AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R3

endmodule

// File: rtl/rxw_down_timer.sv
module rxw_down_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire,
  output logic [CNT_W-1:0] remaining
);

  // Expiry coincides with the last tick, so a count of N spans N ticks.
  assign expire = (remaining == '0) || (tick && remaining == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
    end else if (load) begin
      remaining <= load_val;
    end else if (tick && remaining != '0) begin
      remaining <= remaining - 1'b1;
    end
  end

  AST_TIMER_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (remaining == '0 && !load) |=> (remaining == '0)); // R4

endmodule

// File: rtl/rxw_line_sync.sv
module rxw_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic host_oe,
  input  logic host_level,
  output logic line_level,
  output logic line_sync
);

  logic meta;

  // Weak pull-up: the line reads high whenever the host is not driving.
  assign line_level = host_oe ? host_level : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta      <= 1'b1;
      line_sync <= 1'b1;
    end else begin
      meta      <= line_level;
      line_sync <= meta;
    end
  end

  AST_SYNC_TWO_STAGES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_sync) |-> $past(line_level, 2)); // R11

endmodule

// File: rtl/rxw_ctrl.sv
module rxw_ctrl
  import rxw_pkg::*;
#(
  parameter int BASE_CYCLES = 4,
  parameter int CNT_W       = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       host_oe,
  input  logic       host_level,
  output logic       line_level,
  output logic       rx_en
);

  logic             cyc_en;
  logic [1:0]       on_sel;
  logic [1:0]       off_sel;
  logic [CNT_W-1:0] on_cnt;
  logic [CNT_W-1:0] off_cnt;
  logic             line_sync;
  logic             tick;
  logic             t_expire;
  logic [CNT_W-1:0] t_rem;

  rxw_state_e       state, state_nx;
  logic             phase_load;
  logic [CNT_W-1:0] phase_val;
  logic [1:0]       phase_sel;

  rxw_regfile #(.CNT_W(CNT_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cyc_en  (cyc_en),
    .on_sel  (on_sel),
    .off_sel (off_sel),
    .on_cnt  (on_cnt),
    .off_cnt (off_cnt)
  );

  rxw_line_sync u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_oe    (host_oe),
    .host_level (host_level),
    .line_level (line_level),
    .line_sync  (line_sync)
  );

  assign phase_sel = (state == ST_ON) ? on_sel : off_sel;

  rxw_prescaler #(.BASE_CYCLES(BASE_CYCLES)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (phase_load),
    .sel   (phase_sel),
    .tick  (tick)
  );

  rxw_down_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (phase_load),
    .load_val  (phase_val),
    .tick      (tick),
    .expire    (t_expire),
    .remaining (t_rem)
  );

  always_comb begin
    state_nx   = state;
    phase_load = 1'b0;
    phase_val  = off_cnt;
    if (!cyc_en) begin
      state_nx = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (line_sync) begin
            state_nx   = ST_OFF;
            phase_load = 1'b1;
          end
        end
        ST_OFF: begin
          if (t_expire) begin
            phase_load = 1'b1;
            if (on_cnt != '0) begin
              state_nx  = ST_ON;
              phase_val = on_cnt;
            end
          end
        end
        ST_ON: begin
          if (t_expire) begin
            if (!line_sync) begin
              state_nx = ST_HOLD;
            end else begin
              state_nx   = ST_OFF;
              phase_load = 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (line_sync) begin
            state_nx   = ST_OFF;
            phase_load = 1'b1;
          end
        end
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rx_en <= 1'b0;
    end else begin
      state <= state_nx;
      rx_en <= (state_nx == ST_ON) || (state_nx == ST_HOLD);
    end
  end

  AST_DISABLE_DROPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_en |=> !rx_en); // R10

  AST_LISTEN_HAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ON) |-> (t_rem != '0)); // R7

  AST_HOLD_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> !$past(line_sync)); // R8

  AST_EXPIRY_HIGH_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ON && $past(t_expire) && $past(line_sync) && $past(cyc_en)) |-> (state == ST_OFF)); // R9

  AST_RISE_FROM_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_en) |-> ($past(state) == ST_OFF)); // R6

endmodule

// File: tb/test_rxw_ctrl.sv
module test_rxw_ctrl;

  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic       host_oe = 1'b0;
  logic       host_level = 1'b1;
  logic       line_level;
  logic       rx_en;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rxw_ctrl #(.BASE_CYCLES(BASE), .CNT_W(16)) i_rxw_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .host_oe    (host_oe),
    .host_level (host_level),
    .line_level (line_level),
    .rx_en      (rx_en)
  );

  // {on count, on sel, off count, off sel, expected on cycles, expected off cycles}
  localparam logic [67:0] VEC [5] = '{
    {16'd3,     2'd0, 16'd2, 2'd1, 16'd12,   16'd32},
    {16'd1,     2'd2, 16'd1, 2'd0, 16'd64,   16'd4},
    {16'd2,     2'd3, 16'd5, 2'd0, 16'd512,  16'd20},
    {16'h0100,  2'd0, 16'd3, 2'd2, 16'd1024, 16'd192},
    {16'd7,     2'd1, 16'd1, 2'd3, 16'd112,  16'd256}
  };

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_counts(input logic [15:0] on, input logic [15:0] off);
    wr(8'h0A, 8'h00);
    wr(8'h0B, on[15:8]);
    wr(8'h0C, on[7:0]);
    wr(8'h0D, off[15:8]);
    wr(8'h0E, off[7:0]);
  endtask

  task automatic go(input logic [1:0] onsel, input logic [1:0] offsel);
    wr(8'h0A, {3'b000, offsel, onsel, 1'b1});
  endtask

  task automatic wait_rise(input int lim, output bit found);
    found = 1'b0;
    for (int i = 0; i < lim && !found; i++) begin
      @(negedge clk);
      if (rx_en) found = 1'b1;
    end
  endtask

  // Called at the falling edge where rx_en is first seen high (index 0).
  task automatic burst_len(input int rel_idx, output int len);
    int i;
    len = 0; i = 0;
    while (rx_en && len < 100000) begin
      len++;
      if (i == rel_idx) host_oe = 1'b0;
      i++;
      @(negedge clk);
    end
  endtask

  task automatic gap_len(output int len);
    len = 0;
    while (!rx_en && len < 100000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit found;
    int len;
    int cnt;

    repeat (3) @(negedge clk);
    chk("R1", "rx_en in reset", rx_en, 0);
    chk("R11", "undriven line in reset", line_level, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rx_en after reset", rx_en, 0);

    // R1 / R7: counts reset to zero, so enabling alone gives no window.
    go(2'd0, 2'd0);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (rx_en) cnt++; end
    chk("R7", "rx_en cycles with zero listen count", cnt, 0);

    // R11: line resolution.
    host_oe = 1'b1; host_level = 1'b0; #1;
    chk("R11", "driven low", line_level, 0);
    host_level = 1'b1; #1;
    chk("R11", "driven high", line_level, 1);
    host_oe = 1'b0; host_level = 1'b0; #1;
    chk("R11", "released line", line_level, 1);
    host_level = 1'b1;

    // R3 / R4 / R5: table of counts and time bases.
    for (int v = 0; v < 5; v++) begin
      program_counts(VEC[v][67:52], VEC[v][49:34]);
      go(VEC[v][51:50], VEC[v][33:32]);
      wait_rise(5000, found);
      chk("R6", "listen window starts", found, 1);
      burst_len(-1, len);
      chk("R4", "listen length (R3 base)", len, VEC[v][31:16]);
      gap_len(len);
      chk("R5", "sleep length (R3 base)", len, VEC[v][15:0]);
    end

    // R2: writes to unmapped addresses change nothing.
    program_counts(16'd2, 16'd1);
    wr(8'h0F, 8'hFF);
    wr(8'h09, 8'hFF);
    wr(8'hB0, 8'hFF);
    go(2'd0, 2'd0);
    wait_rise(2000, found);
    chk("R2", "window after unmapped writes", found, 1);
    burst_len(-1, len);
    chk("R2", "listen length after unmapped writes", len, 8);

    // R8: host holds the line past the window end.
    program_counts(16'd4, 16'd2);
    go(2'd0, 2'd0);
    wait_rise(2000, found);
    host_oe = 1'b1; host_level = 1'b0;
    cnt = 0;
    repeat (60) begin @(negedge clk); if (!rx_en) cnt++; end
    chk("R8", "low cycles while held", cnt, 0);
    host_oe = 1'b0;
    @(negedge clk); chk("R8", "rx_en 1st edge after release", rx_en, 1);
    @(negedge clk); chk("R8", "rx_en 2nd edge after release", rx_en, 1);
    @(negedge clk); chk("R8", "rx_en 3rd edge after release", rx_en, 0);

    // R9 / R8: line release lands exactly on the window end, then one cycle later.
    program_counts(16'd4, 16'd2);
    go(2'd0, 2'd0);
    wait_rise(2000, found);
    host_oe = 1'b1; host_level = 1'b0;
    burst_len(13, len);
    chk("R9", "window with release at expiry", len, 16);
    gap_len(len);
    chk("R9", "sleep after expiry with line high", len, 8);
    host_oe = 1'b1; host_level = 1'b0;
    burst_len(14, len);
    chk("R8", "window with release one cycle late", len, 17);
    host_oe = 1'b0;

    // R6: start waits for the line to be high, then sleeps first.
    wr(8'h0A, 8'h00);
    host_oe = 1'b1; host_level = 1'b0;
    program_counts(16'd3, 16'd2);
    go(2'd0, 2'd0);
    cnt = 0;
    repeat (200) begin @(negedge clk); if (rx_en) cnt++; end
    chk("R6", "no start while line low", cnt, 0);
    host_oe = 1'b0;
    cnt = 0;
    do begin @(negedge clk); cnt++; end while (!rx_en && cnt < 1000);
    chk("R6", "edges from release to rx_en", cnt, 11);
    burst_len(-1, len);
    chk("R4", "listen length after start", len, 12);

    // R10: disable mid-window.
    program_counts(16'd100, 16'd1);
    go(2'd0, 2'd0);
    wait_rise(2000, found);
    repeat (10) @(negedge clk);
    wr(8'h0A, 8'h00);
    @(negedge clk);
    chk("R10", "rx_en after disable", rx_en, 0);
    cnt = 0;
    repeat (300) begin @(negedge clk); if (rx_en) cnt++; end
    chk("R10", "rx_en cycles while disabled", cnt, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule